// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block decides, from the current contents of the ID, EX, MEM and WB pipeline registers of an in-order integer pipeline, how the datapath must react to hazards. It selects where each EX-stage operand comes from (register file, the result waiting in the EX/MEM register, or the result waiting in the MEM/WB register). It freezes the front end when a loaded value is needed too early, or when the single shared memory port is taken by a data access. It also turns the wrong-path instruction into a bubble when a branch resolved in ID is taken.

Every output is a combinational function of the stage inputs in the same cycle. The pipeline registers, PC logic and memory sit outside the block and act on the enables it produces. The register file is assumed to write in the first half of a cycle and read in the second, so a producer in WB is visible to an ID read without forwarding.

A front-end stall holds PC and IF/ID and loads a bubble into ID/EX. Under predict-not-taken, a branch found taken in ID clears IF/ID so that the fall-through fetch is dropped. This happens only in a cycle in which the branch actually leaves ID.

Top module: `hazard_ctrl`

## Requirements
- R1: An EX operand whose source index equals the destination of a valid, register-writing instruction in MEM gets select 2'b10 (EX/MEM result).
- R2: Otherwise, if the source index equals the destination of a valid, register-writing instruction in WB, the select is 2'b01 (MEM/WB result); with no match the select is 2'b00 (register file).
- R3: When both MEM and WB match the same operand, the younger MEM producer wins (select 2'b10).
- R4: Register index 0 never produces a forward select other than 2'b00 and never causes a load-use stall.
- R5: A stage whose valid bit is clear, or whose write flag is clear (stores, bubbles), never causes forwarding or a load-use stall.
- R6: A valid load in EX whose destination matches a source that the valid ID instruction actually reads raises stall_pc_o, stall_ifid_o and bubble_o in that cycle; a matching source that ID does not read causes nothing.
- R7: A non-load producer in EX that matches an ID source causes no stall.
- R8: A valid load or store in MEM raises stall_pc_o, stall_ifid_o and bubble_o, because fetch cannot use the memory port that cycle.
- R9: A valid ID instruction with id_br_taken_i set and no stall raises squash_ifid_o only; a branch not taken raises no control output.
- R10: When a stall and a taken branch arise together, the stall wins and squash_ifid_o stays 0.
- R11: With all valid bits clear, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid_i | input | 1 | ID holds a real instruction |
| id_rs1_i | input | REG_AW | ID source index 1 |
| id_rs2_i | input | REG_AW | ID source index 2 |
| id_use_rs1_i | input | 1 | ID instruction reads source 1 |
| id_use_rs2_i | input | 1 | ID instruction reads source 2 |
| id_br_taken_i | input | 1 | Branch in ID resolved taken |
| ex_valid_i | input | 1 | EX holds a real instruction |
| ex_rs1_i | input | REG_AW | EX operand A source index |
| ex_rs2_i | input | REG_AW | EX operand B source index |
| ex_rd_i | input | REG_AW | EX destination index |
| ex_wr_i | input | 1 | EX instruction writes a register |
| ex_is_load_i | input | 1 | EX instruction is a load |
| mem_valid_i | input | 1 | MEM holds a real instruction |
| mem_rd_i | input | REG_AW | MEM destination index |
| mem_wr_i | input | 1 | MEM instruction writes a register |
| mem_is_load_i | input | 1 | MEM instruction is a load |
| mem_is_store_i | input | 1 | MEM instruction is a store |
| wb_valid_i | input | 1 | WB holds a real instruction |
| wb_rd_i | input | REG_AW | WB destination index |
| wb_wr_i | input | 1 | WB instruction writes a register |
| fwd_a_o | output | 2 | Operand A select: 00 regfile, 01 MEM/WB, 10 EX/MEM |
| fwd_b_o | output | 2 | Operand B select, same encoding |
| stall_pc_o | output | 1 | Hold PC |
| stall_ifid_o | output | 1 | Hold IF/ID |
| bubble_o | output | 1 | Load a bubble into ID/EX |
| squash_ifid_o | output | 1 | Clear IF/ID (wrong-path fetch) |

## Verification
The hardest situation to reach is a cycle in which several hazard sources overlap. One case is a taken branch sitting in ID behind a load that it reads while a store occupies MEM. Another is a single operand index matching both the MEM and the WB producer. Because the block has no state, the bench sets these overlaps up directly: it drives each stage's fields to chosen values in one step and reads the outputs in the same cycle. It also mixes in clear valid bits, clear write flags and index 0 to show that each of those masks the hazard that would otherwise be there.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] src_i,
  input  logic          mem_valid_i,
  input  logic          mem_wr_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          wb_valid_i,
  input  logic          wb_wr_i,
  input  logic [AW-1:0] wb_rd_i,
  output logic [1:0]    sel_o
);
  logic src_nz, hit_mem, hit_wb;

  always_comb begin
    src_nz  = |src_i;
    hit_mem = src_nz && mem_valid_i && mem_wr_i && (mem_rd_i == src_i);
    hit_wb  = src_nz && wb_valid_i  && wb_wr_i  && (wb_rd_i  == src_i);
    // youngest producer first
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  always_comb begin
    a_r4_zero_not_fwd: assert (src_i != '0 || sel_o == FWD_RF);
    a_r5_idle_not_fwd: assert ((mem_valid_i && mem_wr_i) || (wb_valid_i && wb_wr_i)
                               || sel_o == FWD_RF);
    a_r2_sel_legal: assert (sel_o != 2'b11);
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          id_valid_i,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_use_rs1_i,
  input  logic          id_use_rs2_i,
  input  logic          ex_valid_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wr_i,
  input  logic          ex_is_load_i,
  output logic          hit_o
);
  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0]   use_v;
  logic [AW-1:0]     src_v [NSRC];
  logic [NSRC-1:0]   match_v;
  logic              ld_prod;

  assign use_v    = {id_use_rs2_i, id_use_rs1_i};
  assign src_v[0] = id_rs1_i;
  assign src_v[1] = id_rs2_i;
  assign ld_prod  = ex_valid_i && ex_wr_i && ex_is_load_i && (ex_rd_i != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign match_v[g] = use_v[g] && (src_v[g] == ex_rd_i);
  end

  assign hit_o = id_valid_i && ld_prod && (|match_v);

  always_comb begin
    a_r4_zero_no_interlock: assert (ex_rd_i != '0 || !hit_o);
    a_r7_alu_no_interlock: assert (ex_is_load_i || !hit_o);
    a_r6_unused_src_ignored: assert ((id_use_rs1_i || id_use_rs2_i) || !hit_o);
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          id_valid_i,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_use_rs1_i,
  input  logic          id_use_rs2_i,
  input  logic          id_br_taken_i,
  input  logic          ex_valid_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wr_i,
  input  logic          ex_is_load_i,
  input  logic          mem_valid_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_wr_i,
  input  logic          mem_is_load_i,
  input  logic          mem_is_store_i,
  input  logic          wb_valid_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_wr_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          stall_pc_o,
  output logic          stall_ifid_o,
  output logic          bubble_o,
  output logic          squash_ifid_o
);
  localparam int unsigned NOPS = 2;

  logic [AW-1:0] op_src [NOPS];
  logic [1:0]    op_sel [NOPS];
  logic          load_use, port_busy, front_stall;

  assign op_src[0] = ex_rs1_i;
  assign op_src[1] = ex_rs2_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_fwd_sel #(.AW(AW)) u_fwd (
      .src_i      (op_src[g]),
      .mem_valid_i(mem_valid_i),
      .mem_wr_i   (mem_wr_i),
      .mem_rd_i   (mem_rd_i),
      .wb_valid_i (wb_valid_i),
      .wb_wr_i    (wb_wr_i),
      .wb_rd_i    (wb_rd_i),
      .sel_o      (op_sel[g])
    );
  end

  assign fwd_a_o = op_sel[0];
  assign fwd_b_o = op_sel[1];

  hz_load_use #(.AW(AW)) u_lu (
    .id_valid_i  (id_valid_i),
    .id_rs1_i    (id_rs1_i),
    .id_rs2_i    (id_rs2_i),
    .id_use_rs1_i(id_use_rs1_i),
    .id_use_rs2_i(id_use_rs2_i),
    .ex_valid_i  (ex_valid_i),
    .ex_rd_i     (ex_rd_i),
    .ex_wr_i     (ex_wr_i),
    .ex_is_load_i(ex_is_load_i),
    .hit_o       (load_use)
  );

  // data access owns the single memory port this cycle
  assign port_busy   = mem_valid_i && (mem_is_load_i || mem_is_store_i);
  assign front_stall = load_use || port_busy;

  assign stall_pc_o    = front_stall;
  assign stall_ifid_o  = front_stall;
  assign bubble_o      = front_stall;
  // squash only when the branch actually leaves ID
  assign squash_ifid_o = id_valid_i && id_br_taken_i && !front_stall;

  always_comb begin
    a_r10_stall_beats_squash: assert (!(squash_ifid_o && stall_ifid_o));
    a_r8_port_conflict_stalls: assert (!port_busy || (stall_pc_o && bubble_o));
    a_r9_squash_needs_branch: assert (!squash_ifid_o || (id_valid_i && id_br_taken_i));
    a_r11_idle_quiet: assert ((id_valid_i || ex_valid_i || mem_valid_i || wb_valid_i)
                              || !(stall_pc_o || squash_ifid_o || fwd_a_o != 2'b00
                                   || fwd_b_o != 2'b00));
  end
endmodule

// File: tb/hazard_ctrl_bench.sv
module hazard_ctrl_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          id_valid, id_use1, id_use2, id_br;
  logic [AW-1:0] id_rs1, id_rs2;
  logic          ex_valid, ex_wr, ex_ld;
  logic [AW-1:0] ex_rs1, ex_rs2, ex_rd;
  logic          mem_valid, mem_wr, mem_ld, mem_st;
  logic [AW-1:0] mem_rd;
  logic          wb_valid, wb_wr;
  logic [AW-1:0] wb_rd;
  logic [1:0]    fwd_a, fwd_b;
  logic          st_pc, st_ifid, bub, sq;

  int n_run = 0;
  int n_fail = 0;

  hazard_ctrl #(.AW(AW)) u_hazard_ctrl (
    .id_valid_i(id_valid), .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .id_use_rs1_i(id_use1), .id_use_rs2_i(id_use2), .id_br_taken_i(id_br),
    .ex_valid_i(ex_valid), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_wr_i(ex_wr), .ex_is_load_i(ex_ld),
    .mem_valid_i(mem_valid), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .mem_is_load_i(mem_ld), .mem_is_store_i(mem_st),
    .wb_valid_i(wb_valid), .wb_rd_i(wb_rd), .wb_wr_i(wb_wr),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_pc_o(st_pc), .stall_ifid_o(st_ifid),
    .bubble_o(bub), .squash_ifid_o(sq)
  );

  task automatic idle();
    @(negedge clk);
    id_valid = 0; id_use1 = 0; id_use2 = 0; id_br = 0; id_rs1 = 0; id_rs2 = 0;
    ex_valid = 0; ex_wr = 0; ex_ld = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
    mem_valid = 0; mem_wr = 0; mem_ld = 0; mem_st = 0; mem_rd = 0;
    wb_valid = 0; wb_wr = 0; wb_rd = 0;
  endtask

  // packed expectation: {fwd_a, fwd_b, stall_pc, stall_ifid, bubble, squash}
  task automatic expect_out(string req, logic [7:0] exp);
    logic [7:0] act;
    #1;
    act = {fwd_a, fwd_b, st_pc, st_ifid, bub, sq};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic t_r11_idle();
    idle();
    expect_out("R11 all idle", 8'b00_00_0000);
  endtask

  task automatic t_r1_r2_fwd();
    idle(); ex_valid = 1; ex_rs1 = 5'd3; ex_rs2 = 5'd7;
    mem_valid = 1; mem_wr = 1; mem_rd = 5'd3;
    expect_out("R1 EX/MEM to A", 8'b10_00_0000);
    idle(); ex_valid = 1; ex_rs1 = 5'd3; ex_rs2 = 5'd7;
    wb_valid = 1; wb_wr = 1; wb_rd = 5'd7;
    expect_out("R2 MEM/WB to B", 8'b00_01_0000);
    idle(); ex_valid = 1; ex_rs1 = 5'd9; ex_rs2 = 5'd9;
    mem_valid = 1; mem_wr = 1; mem_rd = 5'd4; wb_valid = 1; wb_wr = 1; wb_rd = 5'd5;
    expect_out("R2 no match regfile", 8'b00_00_0000);
  endtask

  task automatic t_r3_priority();
    idle(); ex_valid = 1; ex_rs1 = 5'd6; ex_rs2 = 5'd6;
    mem_valid = 1; mem_wr = 1; mem_rd = 5'd6; wb_valid = 1; wb_wr = 1; wb_rd = 5'd6;
    expect_out("R3 youngest wins", 8'b10_10_0000);
    idle(); ex_valid = 1; ex_rs1 = 5'd6; ex_rs2 = 5'd8;
    mem_valid = 1; mem_wr = 1; mem_rd = 5'd8; wb_valid = 1; wb_wr = 1; wb_rd = 5'd6;
    expect_out("R3 split sources", 8'b01_10_0000);
  endtask

  task automatic t_r4_zero();
    idle(); ex_valid = 1; ex_rs1 = 0; ex_rs2 = 0;
    mem_valid = 1; mem_wr = 1; mem_rd = 0; wb_valid = 1; wb_wr = 1; wb_rd = 0;
    expect_out("R4 r0 not forwarded", 8'b00_00_0000);
    idle(); id_valid = 1; id_use1 = 1; id_rs1 = 0;
    ex_valid = 1; ex_wr = 1; ex_ld = 1; ex_rd = 0;
    expect_out("R4 r0 no interlock", 8'b00_00_0000);
  endtask

  task automatic t_r5_masked();
    idle(); ex_valid = 1; ex_rs1 = 5'd2; ex_rs2 = 5'd2;
    mem_valid = 0; mem_wr = 1; mem_rd = 5'd2; wb_valid = 1; wb_wr = 0; wb_rd = 5'd2;
    expect_out("R5 invalid/nonwriting ignored", 8'b00_00_0000);
    idle(); id_valid = 1; id_use1 = 1; id_rs1 = 5'd4;
    ex_valid = 0; ex_wr = 1; ex_ld = 1; ex_rd = 5'd4;
    expect_out("R5 bubble load no stall", 8'b00_00_0000);
    idle(); id_valid = 1; id_use1 = 1; id_rs1 = 5'd4;
    ex_valid = 1; ex_wr = 0; ex_ld = 1; ex_rd = 5'd4;
    expect_out("R5 nonwriting no stall", 8'b00_00_0000);
  endtask

  task automatic t_r6_load_use();
    idle(); id_valid = 1; id_use2 = 1; id_rs2 = 5'd11;
    ex_valid = 1; ex_wr = 1; ex_ld = 1; ex_rd = 5'd11;
    expect_out("R6 load-use on rs2", 8'b00_00_1110);
    idle(); id_valid = 1; id_use1 = 0; id_rs1 = 5'd11; id_use2 = 1; id_rs2 = 5'd12;
    ex_valid = 1; ex_wr = 1; ex_ld = 1; ex_rd = 5'd11;
    expect_out("R6 unused source ignored", 8'b00_00_0000);
    idle(); id_valid = 0; id_use1 = 1; id_rs1 = 5'd11;
    ex_valid = 1; ex_wr = 1; ex_ld = 1; ex_rd = 5'd11;
    expect_out("R6 empty ID no stall", 8'b00_00_0000);
  endtask

  task automatic t_r7_alu();
    idle(); id_valid = 1; id_use1 = 1; id_rs1 = 5'd13;
    ex_valid = 1; ex_wr = 1; ex_ld = 0; ex_rd = 5'd13;
    expect_out("R7 alu producer no stall", 8'b00_00_0000);
  endtask

  task automatic t_r8_port();
    idle(); mem_valid = 1; mem_st = 1;
    expect_out("R8 store owns port", 8'b00_00_1110);
    idle(); mem_valid = 1; mem_ld = 1; mem_wr = 1; mem_rd = 5'd1;
    expect_out("R8 load owns port", 8'b00_00_1110);
    idle(); mem_valid = 0; mem_st = 1;
    expect_out("R8 invalid store no stall", 8'b00_00_0000);
  endtask

  task automatic t_r9_branch();
    idle(); id_valid = 1; id_br = 1;
    expect_out("R9 taken squashes", 8'b00_00_0001);
    idle(); id_valid = 1; id_br = 0;
    expect_out("R9 not taken free", 8'b00_00_0000);
  endtask

  task automatic t_r10_precedence();
    idle(); id_valid = 1; id_br = 1; id_use1 = 1; id_rs1 = 5'd20;
    ex_valid = 1; ex_wr = 1; ex_ld = 1; ex_rd = 5'd20;
    expect_out("R10 load-use beats squash", 8'b00_00_1110);
    idle(); id_valid = 1; id_br = 1; mem_valid = 1; mem_st = 1;
    expect_out("R10 port stall beats squash", 8'b00_00_1110);
    // next cycle: branch leaves ID, squash now applies
    idle(); id_valid = 1; id_br = 1;
    expect_out("R10 squash on release", 8'b00_00_0001);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_r11_idle();
    t_r1_r2_fwd();
    t_r3_priority();
    t_r4_zero();
    t_r5_masked();
    t_r6_load_use();
    t_r7_alu();
    t_r8_port();
    t_r9_branch();
    t_r10_precedence();
    t_r11_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule